// File: doc/BRIEF.md
# Paged ISA Window Address Decoder

This block sits on the address bus of an 8-bit 6502-family host and opens two paths onto a 16-bit ISA card bus. It keeps the video and sound controller selects, but only on the bytes where those chips really have registers. The mirror space that this frees inside $D000-$D7FF is then split three ways. Host page $D5-$D7 becomes a window onto ISA I/O ports $100-$3FF. Pages $D1-$D2 form a 512-byte window into ISA memory. Page $D3 is a local register page.

The memory window is paged. An 11-bit page register, written and read back through the local page, supplies ISA address bits 19..9. The 9-bit window offset supplies bits 8..0, so the host can reach the whole first megabyte. On an I/O access, host line A9 drives ISA bit 9 directly. On a memory access, bit 9 comes from the page register instead.

The ISA command strobes are active low. They are driven only during the high host clock phase. When a card drives its ready line low during a window access, the host ready line goes low as well, and the access stretches until the card lets go. No refresh cycles are ever produced.

Top module: `isa_window_decoder`

## Requirements
- R1: `vid_cs` is high only for host addresses $D000-$D03F. `snd_cs` is high only for $D400-$D43F. Neither is high for any other address, including $D040-$D0FF and $D440-$D4FF.
- R2: A host access to $D500-$D7FF drives `isa_addr` = {10'b0, host_addr[9:0]}, which covers ISA I/O $100-$3FF. A read asserts `isa_ior_n` and a write asserts `isa_iow_n`. No I/O strobe is ever paired with an ISA I/O address below $100.
- R3: A host access to $D100-$D2FF drives `isa_addr` = {page[10:0], ofs[8:0]}, where ofs = host_addr - $D100. A read asserts `isa_memr_n` and a write asserts `isa_memw_n`.
- R4: A command strobe is low only while `host_phi2` is high. At most one strobe is low at a time. `host_rw` = 1 means read.
- R5: The page register is written on a rising `clk` edge while `host_phi2` = 1 and `host_rw` = 0. Byte $D300 takes page[7:0] (ISA bits 16..9). Byte $D301 takes page[10:8] (ISA bits 19..17) from data bits 2..0.
- R6: `local_cs` is high for exactly $D300-$D3FF. `local_rdata` returns page[7:0] at $D300 and {5'b0, page[10:8]} at $D301, and returns 0 at every other local offset.
- R7: Synchronous active-high `rst` clears the page register to 0.
- R8: `host_rdy` is low exactly when an ISA window ($D100-$D2FF or $D500-$D7FF) is addressed and `isa_chrdy` is low. Otherwise it is high.
- R9: Addresses outside all windows produce no select and no strobe, and `isa_addr` is 0.
- R10: A local-page access with `host_phi2` low, a read, or a write to any local offset above $D301 leaves the page register unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock that captures page register writes |
| rst | input | 1 | Synchronous active-high reset |
| host_addr | input | 16 | Host address bus |
| host_rw | input | 1 | 1 = read, 0 = write |
| host_phi2 | input | 1 | Host clock phase; high during data transfer |
| host_wdata | input | 8 | Host write data |
| isa_chrdy | input | 1 | ISA card ready; low requests wait states |
| vid_cs | output | 1 | Video controller select, active high |
| snd_cs | output | 1 | Sound controller select, active high |
| local_cs | output | 1 | Local register page select, active high |
| local_rdata | output | 8 | Local page read data |
| isa_addr | output | 20 | ISA system address SA19..SA0 |
| isa_ior_n | output | 1 | ISA I/O read strobe, active low |
| isa_iow_n | output | 1 | ISA I/O write strobe, active low |
| isa_memr_n | output | 1 | ISA memory read strobe, active low |
| isa_memw_n | output | 1 | ISA memory write strobe, active low |
| host_rdy | output | 1 | Host ready; low stretches the access |

## Verification
The bench probes the edges of every region: $D03F against $D040, $D43F against $D440, $D0FF, $D2FF and $D7FF. A decoder with an off-by-one in a compare would either keep a stray chip select alive in the freed space or open a window one page too wide. The memory checks run with a non-zero page that has bit 0 set. This catches a design that feeds host A9 into ISA bit 9 on memory cycles, or that lets page bits leak into I/O addresses. Further checks cover ignored page writes (phi2 low, a read, a high local offset), the zero-filled upper bits of $D301, and ready stretching. Ready stretching is checked both inside a window and outside it, where a card pulling its ready line low must not stall the host.

// File: rtl/isa_win_pkg.sv
package isa_win_pkg;

    localparam int HOST_AW  = 16;
    localparam int ISA_AW   = 20;
    localparam int OFS_W    = 9;
    localparam int PAGE_W   = ISA_AW - OFS_W;
    localparam int DATA_W   = 8;
    localparam int PAGE_NB  = (PAGE_W + DATA_W - 1) / DATA_W;
    localparam int CHIP_REG_BYTES = 64;

    localparam logic [7:0] VID_PAGE     = 8'hD0;
    localparam logic [7:0] MEM_LO_PAGE  = 8'hD1;
    localparam logic [7:0] MEM_HI_PAGE  = 8'hD2;
    localparam logic [7:0] LOCAL_PAGE   = 8'hD3;
    localparam logic [7:0] SND_PAGE     = 8'hD4;
    localparam logic [7:0] IO_LO_PAGE   = 8'hD5;
    localparam logic [7:0] IO_HI_PAGE   = 8'hD7;
    localparam logic [HOST_AW-1:0] MEM_BASE = 16'hD100;

    typedef enum logic [2:0] {
        RG_NONE,
        RG_VID,
        RG_SND,
        RG_LOCAL,
        RG_ISA_IO,
        RG_ISA_MEM
    } region_e;

    typedef struct packed {
        logic ior;
        logic iow;
        logic memr;
        logic memw;
    } strobe_t;

    function automatic region_e classify(input logic [HOST_AW-1:0] a);
        logic [7:0] hi;
        logic [7:0] lo;
        hi = a[15:8];
        lo = a[7:0];
        if (hi == VID_PAGE && lo < CHIP_REG_BYTES)        return RG_VID;
        if (hi == SND_PAGE && lo < CHIP_REG_BYTES)        return RG_SND;
        if (hi == LOCAL_PAGE)                             return RG_LOCAL;
        if (hi >= MEM_LO_PAGE && hi <= MEM_HI_PAGE)       return RG_ISA_MEM;
        if (hi >= IO_LO_PAGE && hi <= IO_HI_PAGE)         return RG_ISA_IO;
        return RG_NONE;
    endfunction

    function automatic logic [OFS_W-1:0] mem_offset(input logic [HOST_AW-1:0] a);
        return a[OFS_W-1:0] - MEM_BASE[OFS_W-1:0];
    endfunction

endpackage

// File: rtl/isa_region_decode.sv
module isa_region_decode
    import isa_win_pkg::*;
(
    input  logic [HOST_AW-1:0] addr,
    output region_e            region,
    output logic [OFS_W-1:0]   mem_ofs,
    output logic [7:0]         local_ofs
);

    always_comb begin
        region    = classify(addr);
        mem_ofs   = mem_offset(addr);
        local_ofs = addr[7:0];
    end

endmodule

// File: rtl/isa_page_reg.sv
module isa_page_reg
    import isa_win_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [7:0]        idx,
    input  logic [DATA_W-1:0] wdata,
    output logic [PAGE_W-1:0] page,
    output logic [DATA_W-1:0] rdata
);

    logic [PAGE_W-1:0] page_q;
    logic [PAGE_W-1:0] page_d;

    always_comb begin
        page_d = page_q;
        for (int b = 0; b < PAGE_W; b++) begin
            if (wr_en && idx == 8'(b / DATA_W))
                page_d[b] = wdata[b % DATA_W];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) page_q <= '0;
        else     page_q <= page_d;
    end

    always_comb begin
        rdata = '0;
        for (int b = 0; b < PAGE_W; b++) begin
            if (idx == 8'(b / DATA_W))
                rdata[b % DATA_W] = page_q[b];
        end
    end

    assign page = page_q;

    AST_PAGE_HOLD: assert property (@(posedge clk) disable iff (rst)
        !wr_en |=> $stable(page_q)); // R10

    AST_PAGE_RESET: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> page_q == '0); // R7

endmodule

// File: rtl/isa_bus_gen.sv
module isa_bus_gen
    import isa_win_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  region_e           region,
    input  logic [9:0]        io_addr,
    input  logic [OFS_W-1:0]  mem_ofs,
    input  logic [PAGE_W-1:0] page,
    input  logic              rw,
    input  logic              phi2,
    input  logic              chrdy,
    output logic [ISA_AW-1:0] isa_addr,
    output strobe_t           strobe,
    output logic              host_rdy
);

    logic in_window;

    always_comb begin
        in_window = (region == RG_ISA_IO) || (region == RG_ISA_MEM);
        unique case (region)
            RG_ISA_IO:  isa_addr = {{(ISA_AW-10){1'b0}}, io_addr};
            RG_ISA_MEM: isa_addr = {page, mem_ofs};
            default:    isa_addr = '0;
        endcase
        strobe.ior  = phi2 &&  rw && region == RG_ISA_IO;
        strobe.iow  = phi2 && !rw && region == RG_ISA_IO;
        strobe.memr = phi2 &&  rw && region == RG_ISA_MEM;
        strobe.memw = phi2 && !rw && region == RG_ISA_MEM;
        host_rdy    = !(in_window && !chrdy);
    end

    AST_ONE_STROBE: assert property (@(posedge clk) disable iff (rst)
        $onehot0(strobe)); // R4

    AST_STROBE_PHI: assert property (@(posedge clk) disable iff (rst)
        (strobe != '0) |-> phi2); // R4

    AST_IO_FLOOR: assert property (@(posedge clk) disable iff (rst)
        (strobe.ior || strobe.iow) |-> (isa_addr[ISA_AW-1:10] == '0 && isa_addr[9:8] != 2'b00)); // R2

endmodule

// File: rtl/isa_window_decoder.sv
module isa_window_decoder
    import isa_win_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic [HOST_AW-1:0] host_addr,
    input  logic               host_rw,
    input  logic               host_phi2,
    input  logic [DATA_W-1:0]  host_wdata,
    input  logic               isa_chrdy,
    output logic               vid_cs,
    output logic               snd_cs,
    output logic               local_cs,
    output logic [DATA_W-1:0]  local_rdata,
    output logic [ISA_AW-1:0]  isa_addr,
    output logic               isa_ior_n,
    output logic               isa_iow_n,
    output logic               isa_memr_n,
    output logic               isa_memw_n,
    output logic               host_rdy
);

    region_e           region;
    logic [OFS_W-1:0]  mem_ofs;
    logic [7:0]        local_ofs;
    logic [PAGE_W-1:0] page;
    logic [DATA_W-1:0] page_rdata;
    logic              page_wr;
    strobe_t           strobe;

    isa_region_decode u_decode (
        .addr      (host_addr),
        .region    (region),
        .mem_ofs   (mem_ofs),
        .local_ofs (local_ofs)
    );

    assign page_wr = (region == RG_LOCAL) && host_phi2 && !host_rw
                     && (local_ofs < 8'(PAGE_NB));

    isa_page_reg u_page (
        .clk   (clk),
        .rst   (rst),
        .wr_en (page_wr),
        .idx   (local_ofs),
        .wdata (host_wdata),
        .page  (page),
        .rdata (page_rdata)
    );

    isa_bus_gen u_bus (
        .clk      (clk),
        .rst      (rst),
        .region   (region),
        .io_addr  (host_addr[9:0]),
        .mem_ofs  (mem_ofs),
        .page     (page),
        .rw       (host_rw),
        .phi2     (host_phi2),
        .chrdy    (isa_chrdy),
        .isa_addr (isa_addr),
        .strobe   (strobe),
        .host_rdy (host_rdy)
    );

    always_comb begin
        vid_cs      = (region == RG_VID);
        snd_cs      = (region == RG_SND);
        local_cs    = (region == RG_LOCAL);
        local_rdata = local_cs ? page_rdata : '0;
        isa_ior_n   = !strobe.ior;
        isa_iow_n   = !strobe.iow;
        isa_memr_n  = !strobe.memr;
        isa_memw_n  = !strobe.memw;
    end

    AST_CS_EXCL: assert property (@(posedge clk) disable iff (rst)
        $onehot0({vid_cs, snd_cs, local_cs, !isa_ior_n, !isa_iow_n, !isa_memr_n, !isa_memw_n})); // R1

    AST_RDY_WAIT: assert property (@(posedge clk) disable iff (rst)
        !host_rdy |-> !isa_chrdy); // R8

    AST_NO_STRAY: assert property (@(posedge clk) disable iff (rst)
        (host_addr[15:11] != 5'b11010) |-> (isa_addr == '0 && isa_ior_n && isa_iow_n && isa_memr_n && isa_memw_n)); // R9

endmodule

// File: tb/isa_window_decoder_tb.sv
module isa_window_decoder_tb;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [15:0] host_addr = 16'h0000;
    logic        host_rw = 1'b1;
    logic        host_phi2 = 1'b0;
    logic [7:0]  host_wdata = 8'h00;
    logic        isa_chrdy = 1'b1;
    logic        vid_cs, snd_cs, local_cs;
    logic [7:0]  local_rdata;
    logic [19:0] isa_addr;
    logic        isa_ior_n, isa_iow_n, isa_memr_n, isa_memw_n, host_rdy;

    int n_checks = 0;
    int n_fail   = 0;

    always #5 clk = ~clk;

    isa_window_decoder u_dut (
        .clk (clk), .rst (rst),
        .host_addr (host_addr), .host_rw (host_rw), .host_phi2 (host_phi2),
        .host_wdata (host_wdata), .isa_chrdy (isa_chrdy),
        .vid_cs (vid_cs), .snd_cs (snd_cs), .local_cs (local_cs),
        .local_rdata (local_rdata), .isa_addr (isa_addr),
        .isa_ior_n (isa_ior_n), .isa_iow_n (isa_iow_n),
        .isa_memr_n (isa_memr_n), .isa_memw_n (isa_memw_n),
        .host_rdy (host_rdy)
    );

    // {addr, rw phi2 chrdy, vid snd local, ior iow memr memw, isa_addr, host_rdy}
    localparam int NV = 22;
    localparam logic [46:0] VEC [NV] = '{
        {16'hD000, 3'b111, 3'b100, 4'b0000, 20'h00000, 1'b1}, // R1
        {16'hD03F, 3'b011, 3'b100, 4'b0000, 20'h00000, 1'b1}, // R1
        {16'hD040, 3'b111, 3'b000, 4'b0000, 20'h00000, 1'b1}, // R1 R9
        {16'hD0FF, 3'b011, 3'b000, 4'b0000, 20'h00000, 1'b1}, // R1 R9
        {16'hD3FF, 3'b111, 3'b001, 4'b0000, 20'h00000, 1'b1}, // R6
        {16'hD400, 3'b111, 3'b010, 4'b0000, 20'h00000, 1'b1}, // R1
        {16'hD43F, 3'b111, 3'b010, 4'b0000, 20'h00000, 1'b1}, // R1
        {16'hD440, 3'b111, 3'b000, 4'b0000, 20'h00000, 1'b1}, // R1 R9
        {16'hD4FF, 3'b011, 3'b000, 4'b0000, 20'h00000, 1'b1}, // R1 R9
        {16'hD500, 3'b111, 3'b000, 4'b1000, 20'h00100, 1'b1}, // R2
        {16'hD7FF, 3'b011, 3'b000, 4'b0100, 20'h003FF, 1'b1}, // R2
        {16'hD6A5, 3'b101, 3'b000, 4'b0000, 20'h002A5, 1'b1}, // R2 R4
        {16'hD100, 3'b111, 3'b000, 4'b0010, 20'h00000, 1'b1}, // R3
        {16'hD2FF, 3'b011, 3'b000, 4'b0001, 20'h001FF, 1'b1}, // R3
        {16'hD1FF, 3'b111, 3'b000, 4'b0010, 20'h000FF, 1'b1}, // R3
        {16'hD280, 3'b001, 3'b000, 4'b0000, 20'h00180, 1'b1}, // R3 R4
        {16'hD5FF, 3'b110, 3'b000, 4'b1000, 20'h001FF, 1'b0}, // R8
        {16'hD180, 3'b110, 3'b000, 4'b0010, 20'h00080, 1'b0}, // R8
        {16'hD000, 3'b110, 3'b100, 4'b0000, 20'h00000, 1'b1}, // R8
        {16'hDE00, 3'b110, 3'b000, 4'b0000, 20'h00000, 1'b1}, // R8 R9
        {16'hC000, 3'b011, 3'b000, 4'b0000, 20'h00000, 1'b1}, // R9
        {16'hFFFF, 3'b111, 3'b000, 4'b0000, 20'h00000, 1'b1}  // R9
    };

    function automatic logic [27:0] observed();
        return {vid_cs, snd_cs, local_cs, !isa_ior_n, !isa_iow_n,
                !isa_memr_n, !isa_memw_n, isa_addr, host_rdy};
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    endtask

    task automatic drive(input logic [15:0] a, input logic rw, input logic phi, input logic [7:0] d);
        @(negedge clk);
        host_addr  = a;
        host_rw    = rw;
        host_phi2  = phi;
        host_wdata = d;
        #1;
    endtask

    // present an access through one rising edge, then return to idle
    task automatic cycle(input logic [15:0] a, input logic rw, input logic phi, input logic [7:0] d);
        drive(a, rw, phi, d);
        @(posedge clk);
        drive(16'h0000, 1'b1, 1'b0, 8'h00);
    endtask

    task automatic read_local(input logic [15:0] a, input logic [7:0] exp, input string tag);
        drive(a, 1'b1, 1'b1, 8'h00);
        chk(tag, {24'h0, local_rdata}, {24'h0, exp});
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;

        // R7: page register is zero after reset
        read_local(16'hD300, 8'h00, "R7 page low after reset");
        read_local(16'hD301, 8'h00, "R7 page high after reset");

        for (int i = 0; i < NV; i++) begin
            drive(VEC[i][46:31], VEC[i][30], VEC[i][29], 8'h5A);
            isa_chrdy = VEC[i][28];
            #1;
            chk($sformatf("R1/R2/R3/R4/R8/R9 vector %0d addr %h", i, VEC[i][46:31]),
                {4'h0, observed()}, {4'h0, VEC[i][27:0]});
            isa_chrdy = 1'b1;
        end

        // R5: write both page bytes, upper bits of $D301 dropped (R6)
        cycle(16'hD300, 1'b0, 1'b1, 8'hA5);
        cycle(16'hD301, 1'b0, 1'b1, 8'hFF);
        read_local(16'hD300, 8'hA5, "R5 page low write");
        read_local(16'hD301, 8'h07, "R6 page high readback zero-filled");
        read_local(16'hD305, 8'h00, "R6 unused local offset reads zero");

        // R3: memory address with page = 0x7A5 (bit 0 set feeds SA9)
        drive(16'hD123, 1'b1, 1'b1, 8'h00);
        chk("R3 paged memory read address", {12'h0, isa_addr}, 32'h000F4A23);
        chk("R3 memory read strobe", {28'h0, isa_ior_n, isa_iow_n, isa_memr_n, isa_memw_n}, 32'hD);
        drive(16'hD210, 1'b0, 1'b1, 8'h00);
        chk("R3 paged memory write address", {12'h0, isa_addr}, 32'h000F4B10);
        chk("R3 memory write strobe", {28'h0, isa_ior_n, isa_iow_n, isa_memr_n, isa_memw_n}, 32'hE);

        // R2: page contents never reach an I/O address
        drive(16'hD542, 1'b1, 1'b1, 8'h00);
        chk("R2 io address ignores page", {12'h0, isa_addr}, 32'h00000142);

        // R10: ignored page writes
        cycle(16'hD300, 1'b0, 1'b0, 8'h00);
        read_local(16'hD300, 8'hA5, "R10 write with phi2 low ignored");
        cycle(16'hD300, 1'b1, 1'b1, 8'h00);
        read_local(16'hD300, 8'hA5, "R10 read does not write");
        cycle(16'hD302, 1'b0, 1'b1, 8'h00);
        read_local(16'hD300, 8'hA5, "R10 write above $D301 ignored low");
        read_local(16'hD301, 8'h07, "R10 write above $D301 ignored high");

        // R5: second write pattern
        cycle(16'hD300, 1'b0, 1'b1, 8'h3C);
        cycle(16'hD301, 1'b0, 1'b1, 8'h02);
        drive(16'hD2FF, 1'b1, 1'b1, 8'h00);
        chk("R5 rewritten page in address", {12'h0, isa_addr}, 32'h000479FF);

        // R6: local select only on page $D3
        drive(16'hD380, 1'b1, 1'b1, 8'h00);
        chk("R6 local select", {31'h0, local_cs}, 32'h1);

        // R7: reset in mid-run clears the page
        @(negedge clk);
        rst = 1'b1;
        @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        read_local(16'hD300, 8'h00, "R7 page low after second reset");
        read_local(16'hD301, 8'h00, "R7 page high after second reset");

        finish_run();
    end

endmodule